// File: doc/BRIEF.md
# Arbitrated Shared Word Memory with Per-Port Address Streams

This block puts one single-ported word memory behind several processor ports. Each port raises a request with a direction bit and a write word. The port either supplies an explicit word address or asks for the next address from its own address stream. A combinational arbiter picks exactly one requester per cycle. The highest priority level wins. Ties at that level rotate round-robin so that no requester at the winning level waits forever. The chosen access is applied to the array at the next rising clock edge.

Each port owns a stream generator programmed with a base, a step size and a last address. After every granted access that used the stream, the generator moves forward by the step. When the move would pass the last address, it returns to the base. A port that is not served keeps its request and its stream position, so it can retry unchanged. Read words come back one cycle after the grant, tagged with the index of the port that was served.

The array holds 2^AW words of DW bits. With AW = 13 and DW = 16 the array is 16 KB. The default build uses a smaller array to keep elaboration light.

Top module: `shared_mem_arb`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rvalid_o` is 0. After reset every stream is at address 0, with step 1 and last address 2^AW-1.
- R2: In any cycle `gnt_o` has at most one bit set, only for a port whose `req_i` bit is 1. Whenever at least one port requests, exactly one bit is set, within the same cycle.
- R3: A port is granted only if no requesting port has a strictly larger priority level. Levels are PW-bit unsigned fields; port p uses bits [p*PW +: PW] of `prio_i`.
- R4: Among requesters at the winning level, the grant goes to the first one found scanning upward, with wrap-around, from the port after the most recently granted port. After reset the most recently granted port counts as port P-1.
- R5: A granted write (`we_i` bit 1) stores the port's `wdata_i` field at the access address. A granted read drives `rvalid_o`=1 in the next cycle, together with `rport_o` = granted port index and `rdata_o` = the stored word.
- R6: With its `gen_i` bit 0, a port's access address is its `addr_i` field, bits [p*AW +: AW].
- R7: With its `gen_i` bit 1, a port uses its stream position. After each granted access of that kind, the position becomes position+step, or the base if position+step exceeds the last address. A configuration write (`cfg_wr_i`) to port `cfg_port_i` stores base, step and last, and sets the position to the base. This load takes precedence over an advance in the same cycle.
- R8: A port that is not granted, or is granted in explicit mode, keeps its stream position unchanged.
- R9: A configuration write changes only the stream of the port it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | P | Access request per port |
| we_i | input | P | 1 = write, 0 = read, per port |
| gen_i | input | P | 1 = use stream address, 0 = explicit address |
| addr_i | input | P*AW | Explicit word address per port |
| wdata_i | input | P*DW | Write word per port |
| prio_i | input | P*PW | Priority level per port, larger wins |
| cfg_wr_i | input | 1 | Load stream registers of one port |
| cfg_port_i | input | PIW | Port whose stream is loaded |
| cfg_base_i | input | AW | Stream base address |
| cfg_stride_i | input | AW | Stream step |
| cfg_end_i | input | AW | Stream last address |
| gnt_o | output | P | One-hot grant for the current cycle |
| rvalid_o | output | 1 | Read word valid |
| rport_o | output | PIW | Port the read word belongs to |
| rdata_o | output | DW | Read word |

## Verification
The grant depends on the inputs of the same cycle. The bench therefore sets the requests just after a falling edge and compares `gnt_o` one nanosecond later, before the rising edge that commits the access. Read results are registered and due one cycle after their grant. They are checked at the following falling edge, against a bench memory model and against stream and round-robin models that are updated in step with each grant. A stream move or reload shows up only in the address of that port's next granted stream access, so the bench confirms R7, R8 and R9 by the words those later reads return.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int SM_PORTS = 4;
  localparam int SM_AW    = 11;
  localparam int SM_DW    = 16;
  localparam int SM_PW    = 2;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/sm_arbiter.sv
module sm_arbiter #(
  parameter int P   = 4,
  parameter int PW  = 2,
  parameter int PIW = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [P-1:0]    req_i,
  input  logic [P*PW-1:0] prio_i,
  output logic [P-1:0]    gnt_o,
  output logic [PIW-1:0]  gidx_o,
  output logic            any_o
);
  logic [PIW-1:0] last_q;
  logic [PW-1:0]  top_lvl;
  logic [P-1:0]   elig;
  logic           prio_viol;

  always_comb begin
    top_lvl = '0;
    for (int p = 0; p < P; p++)
      if (req_i[p] && prio_i[p*PW +: PW] > top_lvl) top_lvl = prio_i[p*PW +: PW];
    for (int p = 0; p < P; p++)
      elig[p] = req_i[p] && (prio_i[p*PW +: PW] == top_lvl);
  end

  always_comb begin
    int idx;
    logic found;
    gnt_o  = '0;
    gidx_o = '0;
    found  = 1'b0;
    idx    = 0;
    for (int k = 1; k <= P; k++) begin
      idx = (int'(last_q) + k) % P;
      if (!found && elig[idx]) begin
        found       = 1'b1;
        gnt_o[idx]  = 1'b1;
        gidx_o      = PIW'(idx);
      end
    end
    any_o = found;
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= PIW'(P - 1);
    else if (any_o) last_q <= gidx_o;
  end

  always_comb begin
    prio_viol = 1'b0;
    for (int p = 0; p < P; p++)
      for (int q = 0; q < P; q++)
        if (gnt_o[p] && req_i[q] && prio_i[q*PW +: PW] > prio_i[p*PW +: PW])
          prio_viol = 1'b1;
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));
  assert_gnt_only_req_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & ~req_i) == '0);
  assert_gnt_when_req_R2: assert property (@(posedge clk) disable iff (rst)
    (req_i != '0) |-> $countones(gnt_o) == 1);
  assert_prio_order_R3: assert property (@(posedge clk) disable iff (rst)
    !prio_viol);
endmodule

// File: rtl/sm_addr_gen.sv
module sm_addr_gen #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [AW-1:0] end_i,
  input  logic          step_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] base_q, stride_q, end_q, cur_q;
  logic [AW:0]   sum;
  logic          wrap;

  assign sum   = {1'b0, cur_q} + {1'b0, stride_q};
  assign wrap  = sum > {1'b0, end_q};
  assign cur_o = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      stride_q <= AW'(1);
      end_q    <= '1;
      cur_q    <= '0;
    end else if (load_i) begin
      base_q   <= base_i;
      stride_q <= stride_i;
      end_q    <= end_i;
      cur_q    <= base_i;
    end else if (step_i) begin
      cur_q <= wrap ? base_q : sum[AW-1:0];
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step_i && !load_i |=> $stable(cur_q));
  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cur_q == $past(base_i));
  assert_in_window_R7: assert property (@(posedge clk) disable iff (rst)
    step_i && !load_i && (cur_q >= base_q) && (cur_q <= end_q) |=>
    (cur_q >= $past(base_q)) && (cur_q <= $past(end_q)));
endmodule

// File: rtl/sm_sram.sv
module sm_sram #(
  parameter int AW = 11,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en_i && we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (en_i && !we_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/shared_mem_arb.sv
module shared_mem_arb
  import sm_pkg::*;
#(
  parameter int P   = SM_PORTS,
  parameter int AW  = SM_AW,
  parameter int DW  = SM_DW,
  parameter int PW  = SM_PW,
  parameter int PIW = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [P-1:0]    req_i,
  input  logic [P-1:0]    we_i,
  input  logic [P-1:0]    gen_i,
  input  logic [P*AW-1:0] addr_i,
  input  logic [P*DW-1:0] wdata_i,
  input  logic [P*PW-1:0] prio_i,
  input  logic            cfg_wr_i,
  input  logic [PIW-1:0]  cfg_port_i,
  input  logic [AW-1:0]   cfg_base_i,
  input  logic [AW-1:0]   cfg_stride_i,
  input  logic [AW-1:0]   cfg_end_i,
  output logic [P-1:0]    gnt_o,
  output logic            rvalid_o,
  output logic [PIW-1:0]  rport_o,
  output logic [DW-1:0]   rdata_o
);
  logic [PIW-1:0] gidx;
  logic           any_gnt;
  logic [AW-1:0]  cur_addr [P];
  logic [AW-1:0]  eff_addr [P];
  logic [AW-1:0]  acc_addr;
  logic [DW-1:0]  acc_wdata;
  acc_dir_e       acc_dir;
  logic           rvalid_q;
  logic [PIW-1:0] rport_q;

  sm_arbiter #(.P(P), .PW(PW), .PIW(PIW)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .prio_i (prio_i),
    .gnt_o  (gnt_o),
    .gidx_o (gidx),
    .any_o  (any_gnt)
  );

  for (genvar g = 0; g < P; g++) begin : g_port
    sm_addr_gen #(.AW(AW)) u_gen (
      .clk      (clk),
      .rst      (rst),
      .load_i   (cfg_wr_i && (cfg_port_i == PIW'(g))),
      .base_i   (cfg_base_i),
      .stride_i (cfg_stride_i),
      .end_i    (cfg_end_i),
      .step_i   (gnt_o[g] && gen_i[g]),
      .cur_o    (cur_addr[g])
    );
    assign eff_addr[g] = gen_i[g] ? cur_addr[g] : addr_i[g*AW +: AW];
  end

  always_comb begin
    acc_addr  = eff_addr[gidx];
    acc_wdata = wdata_i[gidx*DW +: DW];
    acc_dir   = we_i[gidx] ? ACC_WRITE : ACC_READ;
  end

  sm_sram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .en_i    (any_gnt),
    .we_i    (acc_dir == ACC_WRITE),
    .addr_i  (acc_addr),
    .wdata_i (acc_wdata),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rport_q  <= '0;
    end else begin
      rvalid_q <= any_gnt && (acc_dir == ACC_READ);
      if (any_gnt) rport_q <= gidx;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rport_o  = rport_q;

  assert_read_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0) && ((gnt_o & we_i) == '0) |=>
    rvalid_o && gnt_o == '0 || rvalid_o);
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0) |=> !rvalid_o);
  assert_tag_match_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0) && ((gnt_o & we_i) == '0) |=>
    (P'(1) << rport_o) == $past(gnt_o));
endmodule

// File: tb/tb_shared_mem_arb.sv
`timescale 1ns/1ps
module tb_shared_mem_arb;
  localparam int P = 4, AW = 11, DW = 16, PW = 2, PIW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic [P-1:0] req_v = '0, we_v = '0, gen_v = '0;
  logic [P*AW-1:0] addr_v = '0;
  logic [P*DW-1:0] wdata_v = '0;
  logic [P*PW-1:0] prio_v = '0;
  logic cfg_wr = 1'b0;
  logic [PIW-1:0] cfg_port = '0;
  logic [AW-1:0] cfg_base = '0, cfg_stride = '0, cfg_end = '0;
  logic [P-1:0] gnt;
  logic rvalid;
  logic [PIW-1:0] rport;
  logic [DW-1:0] rdata;

  int ntests = 0, nfail = 0;

  logic [DW-1:0] mmem [DEPTH];
  bit            mval [DEPTH];
  logic [AW-1:0] mptr [P], mbase [P], mstep [P], mend [P];
  int            mlast;

  always #4 clk = ~clk;

  shared_mem_arb #(.P(P), .AW(AW), .DW(DW), .PW(PW)) dut (
    .clk(clk), .rst(rst), .req_i(req_v), .we_i(we_v), .gen_i(gen_v),
    .addr_i(addr_v), .wdata_i(wdata_v), .prio_i(prio_v),
    .cfg_wr_i(cfg_wr), .cfg_port_i(cfg_port), .cfg_base_i(cfg_base),
    .cfg_stride_i(cfg_stride), .cfg_end_i(cfg_end),
    .gnt_o(gnt), .rvalid_o(rvalid), .rport_o(rport), .rdata_o(rdata));

  function automatic int exp_grant();
    int top = 0;
    for (int p = 0; p < P; p++)
      if (req_v[p] && int'(prio_v[p*PW +: PW]) > top) top = int'(prio_v[p*PW +: PW]);
    for (int k = 1; k <= P; k++) begin
      int i = (mlast + k) % P;
      if (req_v[i] && int'(prio_v[i*PW +: PW]) == top) return i;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_port(input int p, input bit r, input bit w, input bit g,
                          input int a, input int d, input int pr);
    req_v[p] = r; we_v[p] = w; gen_v[p] = g;
    addr_v[p*AW +: AW] = AW'(a);
    wdata_v[p*DW +: DW] = DW'(d);
    prio_v[p*PW +: PW] = PW'(pr);
  endtask

  task automatic clear_ports();
    req_v = '0; we_v = '0; gen_v = '0; cfg_wr = 1'b0;
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic step(input string gtag, input string rtag);
    int gi; logic [AW-1:0] a; logic [AW:0] s;
    bit erv, known; int eport; logic [DW-1:0] edat;
    #1;
    gi = exp_grant();
    check(gtag, longint'(gnt), (gi < 0) ? 0 : longint'(1) << gi);
    erv = 0; known = 0; eport = 0; edat = '0;
    if (gi >= 0) begin
      a = gen_v[gi] ? mptr[gi] : addr_v[gi*AW +: AW];
      if (we_v[gi]) begin
        mmem[a] = wdata_v[gi*DW +: DW]; mval[a] = 1;
      end else begin
        erv = 1; eport = gi; known = mval[a]; edat = mmem[a];
      end
      if (gen_v[gi]) begin
        s = {1'b0, mptr[gi]} + {1'b0, mstep[gi]};
        mptr[gi] = (s > {1'b0, mend[gi]}) ? mbase[gi] : s[AW-1:0];
      end
      mlast = gi;
    end
    if (cfg_wr) begin
      mbase[cfg_port] = cfg_base; mstep[cfg_port] = cfg_stride;
      mend[cfg_port] = cfg_end; mptr[cfg_port] = cfg_base;
    end
    @(negedge clk);
    check({rtag, " rvalid"}, longint'(rvalid), longint'(erv));
    if (erv) begin
      check({rtag, " rport"}, longint'(rport), eport);
      if (known) check({rtag, " rdata"}, longint'(rdata), longint'(edat));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    for (int i = 0; i < DEPTH; i++) begin mmem[i] = '0; mval[i] = 0; end
    for (int p = 0; p < P; p++) begin
      mptr[p] = '0; mbase[p] = '0; mstep[p] = AW'(1); mend[p] = '1;
    end
    mlast = P - 1;
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", longint'(rvalid), 0);
    @(negedge clk);
    rst = 1'b0;
    check("R1 rvalid after reset", longint'(rvalid), 0);
    check("R1 idle grant", longint'(gnt), 0);

    // R6: explicit-address fill through rotating ports
    for (int i = 0; i < 32; i++) begin
      clear_ports();
      set_port(i % P, 1, 1, 0, i, 16'h5A00 + i, 0);
      step("R6 fill grant", "R6 fill");
    end
    // R1: reset stream of port 3 starts at 0 and steps by 1
    for (int i = 0; i < 3; i++) begin
      clear_ports();
      set_port(3, 1, 0, 1, 0, 0, 0);
      step("R1 stream grant", "R1 stream read");
    end
    // R3: highest level wins
    clear_ports();
    for (int p = 0; p < P; p++) set_port(p, 1, 0, 0, p, 0, (p == 2) ? 3 : 1);
    step("R3 priority grant", "R3 read");
    // R4: ties rotate
    for (int i = 0; i < 6; i++) begin
      clear_ports();
      for (int p = 0; p < P; p++) set_port(p, 1, 0, 0, p + 4, 0, 2);
      step("R4 round robin grant", "R4 read");
    end
    // R7/R9: reload port 1, wrap check; port 0 stream untouched
    clear_ports();
    cfg_wr = 1'b1; cfg_port = 2'd1; cfg_base = 11'd10; cfg_stride = 11'd3; cfg_end = 11'd16;
    step("R9 cfg grant", "R9 cfg");
    for (int i = 0; i < 5; i++) begin
      clear_ports();
      set_port(1, 1, 0, 1, 0, 0, 2);
      set_port(0, 1, 0, 1, 0, 0, 1);   // R8: held while port 1 served
      step("R7 wrap grant", "R7 wrap read");
    end
    for (int i = 0; i < 2; i++) begin
      clear_ports();
      set_port(0, 1, 0, 1, 0, 0, 0);
      step("R8 held grant", "R8 R9 held read");
    end

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      clear_ports();
      for (int p = 0; p < P; p++)
        set_port(p, ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
                 $urandom % 32, $urandom, $urandom % 2);
      if ($urandom % 16 == 0) begin
        int b;
        b = $urandom % 24;
        cfg_wr = 1'b1; cfg_port = PIW'($urandom % P);
        cfg_base = AW'(b); cfg_stride = AW'(1 + $urandom % 4);
        cfg_end = AW'(b + $urandom % 8);
      end
      step("R2 R3 R4 random grant", "R5 R7 R8 random read");
    end
    clear_ports();
    step("R2 final idle", "R5 final");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule